// File: doc/BRIEF.md
# Nibble-Bus Clock Slave with Burst Stream Port

This block is a slave on a narrow legacy peripheral bus. The bus has four address lines, four data lines, a read/write select and an active-high chip select. The device decodes sixteen register addresses. Addresses 0x0 to 0xE are plain clock registers, and each one returns a BCD time or date nibble. The on-chip timekeeper keeps these registers current through a private write port. The host can also overwrite them over the bus.

Address 0xF is not a clock register. It is a command and stream port. When the host writes a nibble there, it selects one of several buffer banks and rewinds the stream position to the start. Each later read of 0xF returns the nibble at the current position in the selected bank. The position then steps forward once when that read strobe ends. A host can therefore pull a long block of data through a single address without extra address lines. A loader port fills the buffer banks from the chip side.

The host never waits. Read data is produced combinationally from the address while chip select and read are both asserted. All state changes happen on the clock that samples the bus.

Top module: `nrs_rtc_slave`

## Requirements
- R1: `bus_oe` is high exactly when `bus_cs` and `bus_rd` are both high. In every other cycle `bus_oe` is low and `bus_rdata` is 4'h0.
- R2: A read of an address from 0x0 to 0xE returns that clock register's stored nibble in the same cycle. All clock registers hold 4'h0 after reset.
- R3: A bus write (`bus_cs`=1, `bus_rd`=0) to an address from 0x0 to 0xE stores `bus_wdata` in that register. A pulse on `tk_we` stores `tk_data` at `tk_addr`, and the value 0xF on `tk_addr` is ignored. Neither kind of write moves the stream position.
- R4: A bus write to 0xF selects the bank given by the low BANK_W bits of `bus_wdata`, which are bits [1:0] by default. The data bits above BANK_W are ignored.
- R5: A bus write to 0xF sets the stream position to 0.
- R6: A read of 0xF returns the buffer nibble at the selected bank and the current position, in the same cycle.
- R7: The position advances by one in the clock after the cycle in which a read strobe on 0xF ends. This happens once per strobe, however many cycles the strobe lasts. Reads of other addresses, and writes, never advance it.
- R8: Cycles with `bus_cs` low change no register, bank or position.
- R9: The position wraps from 255 back to 0 within the same bank.
- R10: After reset, bank 0 is selected and the position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Chip select, active high |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 4 | Write data from host |
| bus_rdata | output | 4 | Read data to host (0 when not driving) |
| bus_oe | output | 1 | Output enable for the data pads |
| tk_we | input | 1 | Timekeeper register write strobe |
| tk_addr | input | 4 | Timekeeper register address |
| tk_data | input | 4 | Timekeeper BCD nibble |
| ld_we | input | 1 | Buffer loader write strobe |
| ld_bank | input | 2 | Buffer loader bank |
| ld_idx | input | 8 | Buffer loader position |
| ld_data | input | 4 | Buffer loader nibble |

## Verification
The assertions assume that the bus inputs are synchronous to `clk`. They also assume that one host cycle spans at least one clock edge, so that the end of a strobe on 0xF shows up as a sampled high-to-low change. The bench drives every bus and loader input on the falling edge and holds each cycle across at least one rising edge. Random operations draw from legal reads, writes, chip-select-low noise and timekeeper updates, so every change of state is one that the model can account for.

// File: rtl/nrs_pkg.sv
package nrs_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 4;
    localparam logic [ADDR_W-1:0] STREAM_ADDR = 4'hF;
    localparam int NUM_CLK_REGS = 15;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] nib_t;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_t;

    typedef struct packed {
        cyc_kind_t kind;
        logic      stream;
        addr_t     addr;
        nib_t      data;
    } bus_req_t;

    function automatic logic is_stream(input addr_t a);
        return a == STREAM_ADDR;
    endfunction

    function automatic cyc_kind_t classify(input logic cs, input logic rd);
        if (!cs) return CYC_IDLE;
        return rd ? CYC_READ : CYC_WRITE;
    endfunction

endpackage

// File: rtl/nrs_decode.sv
module nrs_decode
    import nrs_pkg::*;
(
    input  logic     bus_cs,
    input  logic     bus_rd,
    input  addr_t    bus_addr,
    input  nib_t     bus_wdata,
    output bus_req_t req
);
    always_comb begin
        req.kind   = classify(bus_cs, bus_rd);
        req.stream = is_stream(bus_addr);
        req.addr   = bus_addr;
        req.data   = bus_wdata;
    end
endmodule

// File: rtl/nrs_clkregs.sv
module nrs_clkregs
    import nrs_pkg::*;
#(
    parameter int NREG = NUM_CLK_REGS
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    input  logic     tk_we,
    input  addr_t    tk_addr,
    input  nib_t     tk_data,
    output nib_t     rd_data
);
    nib_t regs [NREG];

    logic host_wr;
    logic tk_ok;

    assign host_wr = (req.kind == CYC_WRITE) && !req.stream && (int'(req.addr) < NREG);
    assign tk_ok   = tk_we && !is_stream(tk_addr) && (int'(tk_addr) < NREG);

    // The host write is applied after the timekeeper write, so it takes priority on a clash
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            if (tk_ok)   regs[tk_addr]  <= tk_data;
            if (host_wr) regs[req.addr] <= req.data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(req.addr) < NREG) rd_data = regs[req.addr];
    end
endmodule

// File: rtl/nrs_stream_ctl.sv
module nrs_stream_ctl
    import nrs_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int POS_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    output logic [BANK_W-1:0] bank,
    output logic [POS_W-1:0]  pos
);
    logic rd_strobe;
    logic rd_strobe_q;
    logic sel_wr;
    logic trail;

    assign rd_strobe = (req.kind == CYC_READ)  && req.stream;
    assign sel_wr    = (req.kind == CYC_WRITE) && req.stream;
    assign trail     = rd_strobe_q && !rd_strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_strobe_q <= 1'b0;
            bank        <= '0;
            pos         <= '0;
        end else begin
            rd_strobe_q <= rd_strobe;
            if (sel_wr) begin
                bank <= req.data[BANK_W-1:0];
                pos  <= '0;
            end else if (trail) begin
                pos <= pos + 1'b1;
            end
        end
    end
endmodule

// File: rtl/nrs_buffer.sv
module nrs_buffer
    import nrs_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int POS_W  = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [POS_W-1:0]  wr_idx,
    input  nib_t              wr_data,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [POS_W-1:0]  rd_pos,
    output nib_t              rd_data
);
    localparam int NBANK = 1 << BANK_W;
    localparam int DEPTH = 1 << POS_W;

    nib_t bank_out [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        nib_t mem [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == BANK_W'(b))) mem[wr_idx] <= wr_data;
        end
        assign bank_out[b] = mem[rd_pos];
    end

    assign rd_data = bank_out[rd_bank];
endmodule

// File: rtl/nrs_rtc_slave.sv
module nrs_rtc_slave
    import nrs_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int POS_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cs,
    input  logic              bus_rd,
    input  logic [3:0]        bus_addr,
    input  logic [3:0]        bus_wdata,
    output logic [3:0]        bus_rdata,
    output logic              bus_oe,
    input  logic              tk_we,
    input  logic [3:0]        tk_addr,
    input  logic [3:0]        tk_data,
    input  logic              ld_we,
    input  logic [BANK_W-1:0] ld_bank,
    input  logic [POS_W-1:0]  ld_idx,
    input  logic [3:0]        ld_data
);
    bus_req_t          req;
    nib_t              reg_q;
    nib_t              buf_q;
    logic [BANK_W-1:0] stream_bank;
    logic [POS_W-1:0]  stream_pos;

    nrs_decode u_decode (
        .bus_cs   (bus_cs),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .req      (req)
    );

    nrs_clkregs #(.NREG(NUM_CLK_REGS)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .tk_we  (tk_we),
        .tk_addr(tk_addr),
        .tk_data(tk_data),
        .rd_data(reg_q)
    );

    nrs_stream_ctl #(.BANK_W(BANK_W), .POS_W(POS_W)) u_stream (
        .clk (clk),
        .rst (rst),
        .req (req),
        .bank(stream_bank),
        .pos (stream_pos)
    );

    nrs_buffer #(.BANK_W(BANK_W), .POS_W(POS_W)) u_buf (
        .clk    (clk),
        .wr_en  (ld_we),
        .wr_bank(ld_bank),
        .wr_idx (ld_idx),
        .wr_data(ld_data),
        .rd_bank(stream_bank),
        .rd_pos (stream_pos),
        .rd_data(buf_q)
    );

    always_comb begin
        bus_oe    = (req.kind == CYC_READ);
        bus_rdata = '0;
        if (bus_oe) bus_rdata = req.stream ? buf_q : reg_q;
    end
endmodule

// File: rtl/nrs_checker.sv
module nrs_checker #(
    parameter int BANK_W = 2,
    parameter int POS_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_cs,
    input logic              bus_rd,
    input logic [3:0]        bus_addr,
    input logic [3:0]        bus_wdata,
    input logic [3:0]        bus_rdata,
    input logic              bus_oe,
    input logic [BANK_W-1:0] bank,
    input logic [POS_W-1:0]  pos
);
    logic rd_f, wr_f, prev_rd_f;
    logic rst_q = 1'b0;

    assign rd_f = bus_cs &&  bus_rd && (bus_addr == 4'hF);
    assign wr_f = bus_cs && !bus_rd && (bus_addr == 4'hF);

    always_ff @(posedge clk) begin
        rst_q     <= rst;
        prev_rd_f <= rst ? 1'b0 : rd_f;
    end

    always_ff @(posedge clk) begin
        if (rst_q && !rst) AST_RESET_CLEAR: assert (pos == '0 && bank == '0); // R10
    end

    AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(bus_cs && bus_rd) |-> (!bus_oe && bus_rdata == 4'h0)); // R1
    AST_OE_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_cs && bus_rd) |-> bus_oe); // R1
    AST_SEL_BANK: assert property (@(posedge clk) disable iff (rst)
        wr_f |=> bank == $past(bus_wdata[BANK_W-1:0])); // R4
    AST_SEL_REWIND: assert property (@(posedge clk) disable iff (rst)
        wr_f |=> pos == '0); // R5
    AST_STEP_ONCE: assert property (@(posedge clk) disable iff (rst)
        (prev_rd_f && !rd_f && !wr_f) |=> pos == POS_W'($past(pos) + 1'b1)); // R7
    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (rst)
        (!(prev_rd_f && !rd_f) && !wr_f) |=> ($stable(pos) && $stable(bank))); // R8
endmodule

bind nrs_rtc_slave nrs_checker #(.BANK_W(BANK_W), .POS_W(POS_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_cs   (bus_cs),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .bus_oe   (bus_oe),
    .bank     (stream_bank),
    .pos      (stream_pos)
);

// File: tb/nrs_rtc_slave_bench.sv
module nrs_rtc_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BANK_W = 2;
    localparam int POS_W  = 8;
    localparam int NBANK  = 1 << BANK_W;
    localparam int DEPTH  = 1 << POS_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_cs = 0, bus_rd = 0;
    logic [3:0] bus_addr = 0, bus_wdata = 0;
    logic [3:0] bus_rdata;
    logic bus_oe;
    logic tk_we = 0;
    logic [3:0] tk_addr = 0, tk_data = 0;
    logic ld_we = 0;
    logic [BANK_W-1:0] ld_bank = 0;
    logic [POS_W-1:0] ld_idx = 0;
    logic [3:0] ld_data = 0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [3:0] m_regs [15];
    int m_bank = 0;
    int m_pos = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nrs_rtc_slave #(.BANK_W(BANK_W), .POS_W(POS_W)) u_nrs_rtc_slave (.*);

    function automatic logic [3:0] buf_val(input int b, input int i);
        return 4'((b * 5) + (i * 3) + (i >> 3));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_cycle(input logic [3:0] a, input int ncyc, input string req);
        int exp;
        @(negedge clk);
        bus_cs = 1; bus_rd = 1; bus_addr = a;
        exp = (a == 4'hF) ? int'(buf_val(m_bank, m_pos)) : int'(m_regs[a]);
        for (int c = 0; c < ncyc; c++) begin
            if (c > 0) @(negedge clk);
            #1;
            check(req, bus_oe, 1);
            check(req, bus_rdata, exp);
        end
        @(negedge clk);
        bus_cs = 0; bus_rd = 0;
        #1;
        check("R1", {bus_oe, bus_rdata}, 0);
        if (a == 4'hF) m_pos = (m_pos + 1) % DEPTH;
    endtask

    task automatic wr_cycle(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_cs = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
        #1;
        check("R1", {bus_oe, bus_rdata}, 0);
        @(negedge clk);
        bus_cs = 0;
        if (a == 4'hF) begin
            m_bank = int'(d[BANK_W-1:0]);
            m_pos  = 0;
        end else begin
            m_regs[a] = d;
        end
    endtask

    task automatic noise_cycle(input logic rd, input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_cs = 0; bus_rd = rd; bus_addr = a; bus_wdata = d;
        #1;
        check("R8", {bus_oe, bus_rdata}, 0);
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic tk_cycle(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        tk_we = 1; tk_addr = a; tk_data = d;
        @(negedge clk);
        tk_we = 0;
        if (a != 4'hF) m_regs[a] = d;
    endtask

    initial begin
        for (int i = 0; i < 15; i++) m_regs[i] = 4'h0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check("R1", {bus_oe, bus_rdata}, 0);

        for (int b = 0; b < NBANK; b++) begin
            for (int i = 0; i < DEPTH; i++) begin
                @(negedge clk);
                ld_we = 1; ld_bank = BANK_W'(b); ld_idx = POS_W'(i); ld_data = buf_val(b, i);
            end
        end
        @(negedge clk);
        ld_we = 0;

        rd_cycle(4'h5, 1, "R2");
        rd_cycle(4'hF, 1, "R10");
        rd_cycle(4'hF, 1, "R6");
        wr_cycle(4'h3, 4'h7);
        rd_cycle(4'h3, 1, "R3");
        rd_cycle(4'hF, 1, "R7");
        tk_cycle(4'h9, 4'h4);
        tk_cycle(4'hF, 4'h2);
        rd_cycle(4'h9, 1, "R3");
        rd_cycle(4'hF, 1, "R3");

        wr_cycle(4'hF, 4'b0110);
        rd_cycle(4'hF, 1, "R4");
        rd_cycle(4'hF, 4, "R7");
        rd_cycle(4'hF, 1, "R7");
        wr_cycle(4'hF, 4'h2);
        rd_cycle(4'hF, 1, "R5");

        noise_cycle(1'b0, 4'hF, 4'h3);
        noise_cycle(1'b0, 4'h3, 4'h1);
        noise_cycle(1'b1, 4'hF, 4'h0);
        rd_cycle(4'h3, 1, "R8");
        rd_cycle(4'hF, 1, "R8");

        wr_cycle(4'hF, 4'h1);
        for (int i = 0; i < DEPTH; i++) rd_cycle(4'hF, 1, "R6");
        rd_cycle(4'hF, 1, "R9");
        rd_cycle(4'hF, 1, "R9");

        for (int n = 0; n < 500; n++) begin
            int op;
            logic [3:0] a, d;
            op = int'($urandom % 6);
            a  = 4'($urandom);
            d  = 4'($urandom);
            case (op)
                0: rd_cycle(a, 1 + int'($urandom % 3), (a == 4'hF) ? "R6" : "R2");
                1: rd_cycle(4'hF, 1 + int'($urandom % 2), "R7");
                2: if (($urandom % 4) == 0) wr_cycle(4'hF, d); else rd_cycle(4'hF, 1, "R9");
                3: wr_cycle((a == 4'hF) ? 4'hE : a, d);
                4: noise_cycle(1'($urandom), a, d);
                default: tk_cycle(a, d);
            endcase
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule